// File: doc/BRIEF.md
# Fast Single-Word Signal Channel Bank

This block holds eight one-word mailbox slots that let a sending processor hand a single 32-bit value to a receiving processor. There is no acknowledge path. The sender writes a slot's address on its own write port. The slot captures the word and raises a pending flag. The flag for slot n sits at bit 9+n of the shared pending-status word.

The receiver works on a separate read/write port. It enables interrupts per slot with a mask register. When a pending flag meets a set mask bit, the block raises its interrupt. The receiver then clears the flag with a write-one-to-clear access and reads the captured word back.

Only the receiving side is ever interrupted. Each slot holds one value at a time: a later write replaces an unread one. The status, clear and enable words are shared with the other channel types of a larger mailbox, so this bank only owns bits 9 to 16 of them.

Top module: `fast_sig_bank`

## Requirements
- R1: After reset every slot word, every pending flag and every enable bit is zero, the interrupt is low, and the read data output is zero.
- R2: A sender write to byte address 0x8C+4n (n = 0..7) stores the data word in slot n and sets pending flag n, which reads back as bit 9+n of the status word at 0x C8. The flag is visible from the next clock edge.
- R3: The interrupt output is high exactly when some slot n has both its pending flag and enable bit 9+n set. It follows a change of either in the cycle after the edge that made the change.
- R4: A receiver write to 0xC4 clears pending flag n for every data bit 9+n that is one. It leaves flags whose bit is zero alone, and it never changes a slot word.
- R5: When a sender write to slot n and a receiver clear of flag n land in the same cycle, the flag stays set and the slot holds the new word.
- R6: A second sender write to a slot whose flag is still set replaces the word and keeps the flag set.
- R7: A receiver read of 0x8C+4n returns slot n's last written word on the read data output one cycle after the read strobe. The read changes no flag and no word.
- R8: A receiver write to 0xC0 stores data bits 16..9 as the eight enable bits. A read of 0xC0 returns them at bits 16..9 with all other bits zero.
- R9: A read of the status word at 0xC8 returns flag n at bit 9+n with all other bits zero.
- R10: A sender write to any address other than the eight aligned slot addresses has no effect. This includes 0x88, 0xAC, unaligned offsets and the register addresses. A receiver write to a slot address also has no effect.
- R11: A receiver read of the clear register or of any unmapped address returns zero. The read data output is zero in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Sender write strobe |
| tx_addr_i | input | 8 | Sender byte address |
| tx_wdata_i | input | 32 | Sender write data |
| rx_wr_i | input | 1 | Receiver write strobe |
| rx_rd_i | input | 1 | Receiver read strobe |
| rx_addr_i | input | 8 | Receiver byte address |
| rx_wdata_i | input | 32 | Receiver write data |
| rx_rdata_o | output | 32 | Receiver read data, registered, one cycle after the strobe |
| rx_irq_o | output | 1 | Receiver interrupt |

## Verification
Sender and receiver have separate ports, so a new word can arrive at a slot in the same cycle that the receiver clears that slot's flag. The bench drives both strobes in one cycle, on one slot and then on two different slots. It expects the set to win on the shared slot and the clear to take effect on the other. It judges the result by reading the status word and the slot word back through the receiver port.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    // Source selected for the receiver read data register
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_DATA = 2'd1,
        RSEL_ENAB = 2'd2,
        RSEL_STAT = 2'd3
    } rsel_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fsb_dec.sv
module fsb_dec #(
    parameter int NUM_CH    = 8,
    parameter int ADDR_W    = 8,
    parameter int FAST_BASE = 'h8C,
    parameter int ENAB_ADDR = 'hC0,
    parameter int CLR_ADDR  = 'hC4,
    parameter int STAT_ADDR = 'hC8,
    parameter int IDX_W     = fsb_pkg::idx_width(NUM_CH)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              fast_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              enab_o,
    output logic              clr_o,
    output logic              stat_o
);

    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(FAST_BASE);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(FAST_BASE + 4*NUM_CH);

    logic [ADDR_W:0] ext;
    logic [ADDR_W:0] off;
    logic            unused_off_bits;

    always_comb begin
        ext    = {1'b0, addr_i};
        off    = ext - LO;
        fast_o = (ext >= LO) && (ext < HI) && (addr_i[1:0] == 2'b00);
        idx_o  = off[IDX_W+1:2];
        enab_o = (addr_i == ADDR_W'(ENAB_ADDR));
        clr_o  = (addr_i == ADDR_W'(CLR_ADDR));
        stat_o = (addr_i == ADDR_W'(STAT_ADDR));
    end

    assign unused_off_bits = ^off;

endmodule

// File: rtl/fsb_slot.sv
module fsb_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] data_o,
    output logic              flag_o
);

    typedef struct packed {
        logic              flag;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
        // a write in the same cycle as a clear keeps the flag raised
        if (set_i) begin
            st_d.flag = 1'b1;
            st_d.data = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign flag_o = st_q.flag;

    // R2 / R5 / R6
    set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> (flag_o && (data_o == $past(wdata_i))));

    // R4
    clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i) |=> !flag_o);

    // R7 / R10
    idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!set_i && !clr_i) |=> ($stable(flag_o) && $stable(data_o)));

endmodule

// File: rtl/fsb_rd.sv
module fsb_rd #(
    parameter int NUM_CH   = 8,
    parameter int DATA_W   = 32,
    parameter int STAT_LSB = 9,
    parameter int IDX_W    = fsb_pkg::idx_width(NUM_CH)
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           rd_i,
    input  fsb_pkg::rsel_e                 sel_i,
    input  logic [IDX_W-1:0]               idx_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  data_i,
    input  logic [NUM_CH-1:0]              flags_i,
    input  logic [NUM_CH-1:0]              enab_i,
    output logic [DATA_W-1:0]              rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DATA_W-1:0] word;

    always_comb begin
        word = '0;
        unique case (sel_i)
            fsb_pkg::RSEL_DATA: word = data_i[idx_i];
            fsb_pkg::RSEL_ENAB: word[STAT_LSB +: NUM_CH] = enab_i;
            fsb_pkg::RSEL_STAT: word[STAT_LSB +: NUM_CH] = flags_i;
            default:            word = '0;
        endcase
        rd_d.rdata = rd_i ? word : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q.rdata;

    // R11
    quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> (rdata_o == '0));

endmodule

// File: rtl/fast_sig_bank.sv
module fast_sig_bank #(
    parameter int NUM_CH    = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int FAST_BASE = 'h8C,
    parameter int ENAB_ADDR = 'hC0,
    parameter int CLR_ADDR  = 'hC4,
    parameter int STAT_ADDR = 'hC8,
    parameter int STAT_LSB  = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tx_wr_i,
    input  logic [ADDR_W-1:0] tx_addr_i,
    input  logic [DATA_W-1:0] tx_wdata_i,
    input  logic              rx_wr_i,
    input  logic              rx_rd_i,
    input  logic [ADDR_W-1:0] rx_addr_i,
    input  logic [DATA_W-1:0] rx_wdata_i,
    output logic [DATA_W-1:0] rx_rdata_o,
    output logic              rx_irq_o
);

    localparam int IDX_W = fsb_pkg::idx_width(NUM_CH);

    typedef struct packed {
        logic [NUM_CH-1:0] enab;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                          tx_fast;
    logic [IDX_W-1:0]              tx_idx;
    logic                          unused_tx_enab, unused_tx_clr, unused_tx_stat;
    logic                          rx_fast, rx_enab, rx_clr, rx_stat;
    logic [IDX_W-1:0]              rx_idx;
    logic                          unused_rx_wdata;
    logic [NUM_CH-1:0]             set_vec, clr_vec, flags;
    logic [NUM_CH-1:0][DATA_W-1:0] data_all;
    fsb_pkg::rsel_e                rsel;

    fsb_dec #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .FAST_BASE(FAST_BASE),
        .ENAB_ADDR(ENAB_ADDR), .CLR_ADDR(CLR_ADDR), .STAT_ADDR(STAT_ADDR),
        .IDX_W(IDX_W)
    ) u_tx_dec (
        .addr_i (tx_addr_i),
        .fast_o (tx_fast),
        .idx_o  (tx_idx),
        .enab_o (unused_tx_enab),
        .clr_o  (unused_tx_clr),
        .stat_o (unused_tx_stat)
    );

    fsb_dec #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .FAST_BASE(FAST_BASE),
        .ENAB_ADDR(ENAB_ADDR), .CLR_ADDR(CLR_ADDR), .STAT_ADDR(STAT_ADDR),
        .IDX_W(IDX_W)
    ) u_rx_dec (
        .addr_i (rx_addr_i),
        .fast_o (rx_fast),
        .idx_o  (rx_idx),
        .enab_o (rx_enab),
        .clr_o  (rx_clr),
        .stat_o (rx_stat)
    );

    assign unused_rx_wdata = ^rx_wdata_i;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        assign set_vec[g] = tx_wr_i && tx_fast && (tx_idx == IDX_W'(g));
        assign clr_vec[g] = rx_wr_i && rx_clr && rx_wdata_i[STAT_LSB + g];

        fsb_slot #(.DATA_W(DATA_W)) u_slot (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .set_i   (set_vec[g]),
            .clr_i   (clr_vec[g]),
            .wdata_i (tx_wdata_i),
            .data_o  (data_all[g]),
            .flag_o  (flags[g])
        );
    end

    always_comb begin
        ctl_d = ctl_q;
        if (rx_wr_i && rx_enab) begin
            ctl_d.enab = rx_wdata_i[STAT_LSB +: NUM_CH];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        if (rx_fast) begin
            rsel = fsb_pkg::RSEL_DATA;
        end else if (rx_enab) begin
            rsel = fsb_pkg::RSEL_ENAB;
        end else if (rx_stat) begin
            rsel = fsb_pkg::RSEL_STAT;
        end else begin
            rsel = fsb_pkg::RSEL_NONE;
        end
    end

    fsb_rd #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .STAT_LSB(STAT_LSB), .IDX_W(IDX_W)
    ) u_rd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_i    (rx_rd_i),
        .sel_i   (rsel),
        .idx_i   (rx_idx),
        .data_i  (data_all),
        .flags_i (flags),
        .enab_i  (ctl_q.enab),
        .rdata_o (rx_rdata_o)
    );

    assign rx_irq_o = |(flags & ctl_q.enab);

    // R10
    stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_wr_i && !tx_fast && !(rx_wr_i && rx_clr)) |=> $stable(flags));

    // R8
    enab_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_wr_i && rx_enab) |=> (ctl_q.enab == $past(rx_wdata_i[STAT_LSB +: NUM_CH])));

endmodule

// File: tb/tb_fast_sig_bank.sv
module tb_fast_sig_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_addr = '0;
    logic [31:0] tx_wdata = '0;
    logic        rx_wr = 1'b0;
    logic        rx_rd = 1'b0;
    logic [7:0]  rx_addr = '0;
    logic [31:0] rx_wdata = '0;
    logic [31:0] rx_rdata;
    logic        rx_irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference model
    logic [31:0] m_data [8];
    logic [7:0]  m_flags = '0;
    logic [7:0]  m_en = '0;

    // scoreboard
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fast_sig_bank dut (
        .clk_i(clk), .rst_ni(rst_n),
        .tx_wr_i(tx_wr), .tx_addr_i(tx_addr), .tx_wdata_i(tx_wdata),
        .rx_wr_i(rx_wr), .rx_rd_i(rx_rd), .rx_addr_i(rx_addr),
        .rx_wdata_i(rx_wdata), .rx_rdata_o(rx_rdata), .rx_irq_o(rx_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_slot(input logic [7:0] a);
        return (a >= 8'h8C) && (a <= 8'hA8) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] w = '0;
        if (is_slot(a)) w = m_data[(int'(a) - 'h8C) / 4];
        else if (a == 8'hC0) w[16:9] = m_en;
        else if (a == 8'hC8) w[16:9] = m_flags;
        return w;
    endfunction

    function automatic void model_tx(input logic [7:0] a, input logic [31:0] d);
        if (is_slot(a)) begin
            m_data[(int'(a) - 'h8C) / 4] = d;
            m_flags[(int'(a) - 'h8C) / 4] = 1'b1;
        end
    endfunction

    function automatic void model_rx(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'hC0) m_en = d[16:9];
        if (a == 8'hC4) m_flags = m_flags & ~d[16:9];
    endfunction

    task automatic tx_put(input logic [7:0] a, input logic [31:0] d);
        tx_wr = 1'b1; tx_addr = a; tx_wdata = d;
        @(negedge clk);
        tx_wr = 1'b0;
        model_tx(a, d);
    endtask

    task automatic rx_put(input logic [7:0] a, input logic [31:0] d);
        rx_wr = 1'b1; rx_addr = a; rx_wdata = d;
        @(negedge clk);
        rx_wr = 1'b0;
        model_rx(a, d);
    endtask

    // sender write and receiver write in one cycle; a set beats a clear
    task automatic both_put(input logic [7:0] ta, input logic [31:0] td,
                            input logic [7:0] ra, input logic [31:0] rd);
        tx_wr = 1'b1; tx_addr = ta; tx_wdata = td;
        rx_wr = 1'b1; rx_addr = ra; rx_wdata = rd;
        @(negedge clk);
        tx_wr = 1'b0; rx_wr = 1'b0;
        model_rx(ra, rd);
        model_tx(ta, td);
    endtask

    task automatic rx_get(input logic [7:0] a, input string tag);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        rx_rd = 1'b1; rx_addr = a;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    // monitor
    always @(posedge clk) rd_seen <= rx_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underrun", rx_rdata, 32'h0);
                bad++;
            end else begin
                chk(tag_q.pop_front(), rx_rdata, exp_q.pop_front());
            end
        end else if (rst_n && !finished) begin
            // R11 quiet read bus between reads
            if (rx_rdata !== 32'h0) chk("R11 idle rdata", rx_rdata, 32'h0);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) m_data[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, rx_irq}, 32'h0);
        chk("R1 rdata", rx_rdata, 32'h0);
        rx_get(8'hC8, "R1 status");
        rx_get(8'hC0, "R1 enable");
        for (int i = 0; i < 8; i++) rx_get(8'(8'h8C + 4*i), "R1 slot word");

        // R2 write slot 3, interrupt masked
        tx_put(8'h98, 32'hA5A5_0003);
        rx_get(8'h98, "R2 slot3 word");
        rx_get(8'hC8, "R2 status bit 12");
        chk("R3 masked irq", {31'b0, rx_irq}, 32'h0);

        // R8 enable all slots; only bits 16..9 kept
        rx_put(8'hC0, 32'hFFFF_FFFF);
        rx_get(8'hC0, "R8 enable readback");
        chk("R3 irq raised", {31'b0, rx_irq}, 32'h1);

        // R7 repeated reads leave state alone
        rx_get(8'h98, "R7 read one");
        rx_get(8'h98, "R7 read two");
        rx_get(8'hC8, "R7 status after reads");

        // R4 clear slot 3
        rx_put(8'hC4, 32'h0000_1000);
        chk("R4 irq after clear", {31'b0, rx_irq}, 32'h0);
        rx_get(8'hC8, "R4 status cleared");
        rx_get(8'h98, "R4 word kept");

        // R2 / R9 end slots, then partial clear with stray low bits
        tx_put(8'h8C, 32'h1111_0000);
        tx_put(8'hA8, 32'h7777_0007);
        rx_get(8'hC8, "R9 status two bits");
        rx_put(8'hC4, 32'h0000_03FF);
        rx_get(8'hC8, "R4 partial clear");

        // R6 overwrite before clear
        tx_put(8'hA8, 32'hDEAD_BEEF);
        rx_get(8'hA8, "R6 overwritten word");
        rx_get(8'hC8, "R6 flag held");

        // R5 same-cycle set and clear, same slot then different slots
        both_put(8'hA0, 32'h5555_0005, 8'hC4, 32'h0000_4000);
        rx_get(8'hC8, "R5 set beats clear");
        rx_get(8'hA0, "R5 new word");
        both_put(8'h94, 32'h2222_0002, 8'hC4, 32'h0001_0000);
        rx_get(8'hC8, "R5 other slot cleared");

        // R3 selective enable
        rx_put(8'hC4, 32'h0001_FE00);
        rx_put(8'hC0, 32'h0000_0800);
        chk("R3 no pending", {31'b0, rx_irq}, 32'h0);
        tx_put(8'h9C, 32'h4444_0004);
        chk("R3 masked slot", {31'b0, rx_irq}, 32'h0);
        tx_put(8'h94, 32'h2222_1002);
        chk("R3 enabled slot", {31'b0, rx_irq}, 32'h1);

        // R10 stray sender writes and receiver writes to slots
        tx_put(8'h88, 32'hBAD0_0001);
        tx_put(8'hAC, 32'hBAD0_0002);
        tx_put(8'h8D, 32'hBAD0_0003);
        tx_put(8'hC4, 32'hFFFF_FFFF);
        tx_put(8'hC0, 32'h0000_0000);
        rx_put(8'h8C, 32'hBAD0_0004);
        rx_get(8'hC8, "R10 status unchanged");
        rx_get(8'hC0, "R10 enable unchanged");
        rx_get(8'h8C, "R10 slot0 unchanged");
        rx_get(8'h90, "R10 slot1 unchanged");
        chk("R10 irq unchanged", {31'b0, rx_irq}, 32'h1);

        // R11 unmapped and clear-register reads
        rx_get(8'hC4, "R11 clear reads zero");
        rx_get(8'h00, "R11 unmapped low");
        rx_get(8'hAC, "R11 past last slot");
        rx_get(8'h8E, "R11 unaligned");

        @(negedge clk);
        if (exp_q.size() != 0) chk("scoreboard leftover", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule